// File: doc/BRIEF.md
# Instruction Fetch Fault Merger with Storage Integrity Check

This block sits in the stage of an instruction cache that receives the tag and data array read words for each fetch slot. It turns every source of fetch failure into one 2-bit exception code per slot. The sources are the address translation fault, the memory-protection fault and a parity check over the stored tag and instruction words. When a slot's tag word is corrupt and checking is enabled, the block also withdraws that slot's refill or prefetch request to the next cache level. It keeps corrupted instruction words from reaching the backend as valid. Separately from the exception path, it reports every corruption it detects on an error output.

The integrity check is an XOR reduction of each fixed-width segment of a word against the parity bit stored with that segment. The result is registered. The block therefore captures the raw read words, the fault inputs and the request intent on one rising edge and presents all merged outputs after that edge. A global enable input decides whether a detected corruption becomes an access fault. Detections are reported whatever the enable says.

Top module: `fetch_fault_merger`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is 0 after that edge, whatever the inputs.
- R2: Every output is a function only of the inputs sampled at the most recent rising edge. Changing the inputs between edges does not move the outputs.
- R3: A slot's exception code is 01 if its translation fault was set, otherwise 10 if its protection fault was set, otherwise 11 if an enabled integrity failure applies, otherwise 00.
- R4: Even parity is used. The tag word has one stored bit per 10-bit segment and the data word has one per 8-bit byte, with bit g covering segment g. Any single flipped bit in a word or in its parity bits is detected.
- R5: With `parity_en_i` high, a tag failure makes the code 11, and so does a data failure on a hit, unless a higher-priority fault is present.
- R6: With `parity_en_i` low, integrity failures produce no code 11 and do not withdraw a fill request.
- R7: `fill_req_o` is high only for a valid slot that requested a miss, has neither translation nor protection fault, and has no enabled tag failure.
- R8: `data_ok_o` is high only for a valid hit slot whose code is 00.
- R9: `err_tag_o` and `err_data_o` flag a detected tag or data failure on a valid slot regardless of `parity_en_i`. `err_any_o` is the OR of all of them.
- R10: On a slot that requests a miss, the data word check is ignored: it gives no fault and no error report.
- R11: A slot sampled with `rd_valid_i` low drives code 00 and no request, no data-ok and no error flags, whatever its other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| parity_en_i | input | 1 | Turns integrity failures into access faults |
| rd_valid_i | input | SLOTS | Slot carries a fetch this cycle |
| tag_word_i | input | SLOTS*TAG_W | Raw tag array words, slot 0 in the low bits |
| tag_par_i | input | SLOTS*TAG_W/TAG_SEG | Stored tag parity bits |
| data_word_i | input | SLOTS*DATA_W | Raw data array words |
| data_par_i | input | SLOTS*DATA_W/DATA_SEG | Stored data parity bits |
| xlat_fault_i | input | SLOTS | Translation fault per slot |
| prot_fault_i | input | SLOTS | Memory-protection fault per slot |
| miss_req_i | input | SLOTS | Slot missed and wants a refill |
| exc_code_o | output | 2*SLOTS | Merged exception code per slot |
| fill_req_o | output | SLOTS | Surviving refill/prefetch request |
| data_ok_o | output | SLOTS | Instruction word may be delivered |
| err_tag_o | output | SLOTS | Tag corruption detected |
| err_data_o | output | SLOTS | Data corruption detected on a hit |
| err_any_o | output | 1 | Any corruption detected |

## Verification
The bench first targets priority collisions, where a translation or protection fault coincides with a parity failure. A design with the wrong order would report an access fault where the translation code belongs. With the enable low, a corrupted tag must not cancel the refill, yet the error flag must still rise. A design that tied reporting to the enable, or cancellation to the raw check, fails here. A data flip on a missing slot must stay silent, because a design that checked stale data would raise spurious faults. An invalid slot carrying every fault, and a reset taken while inputs are active, must both leave the outputs quiet. The bench also walks all 64 combinations of enable, faults, miss and flips on two slots with different patterns.

// File: rtl/fetch_fault_pkg.sv
// Package: shared exception encoding for the fetch fault merger.
// Assumes a 2-bit code with priority translation > protection > access.
package fetch_fault_pkg;
    typedef enum logic [1:0] {
        EXC_NONE = 2'b00,
        EXC_XLAT = 2'b01,
        EXC_PROT = 2'b10,
        EXC_ACC  = 2'b11
    } exc_code_e;
endpackage

// File: rtl/ffm_parity_check.sv
// ffm_parity_check: registered even-parity check of one array word.
// The word is split into SEG-bit segments, each with one stored parity bit
// (bit g covers segment g). The registered error is valid one cycle after
// the raw read. Assumes W is a multiple of SEG.
module ffm_parity_check #(
    parameter int W   = 32,
    parameter int SEG = 8,
    localparam int PB = W / SEG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en_i,
    input  logic [W-1:0]  word_i,
    input  logic [PB-1:0] par_i,
    output logic          err_o
);
    logic [PB-1:0] seg_bad;
    logic          err_q;

    // Per-segment XOR reduction against the stored bit.
    for (genvar g = 0; g < PB; g++) begin : g_seg
        assign seg_bad[g] = (^word_i[g*SEG +: SEG]) ^ par_i[g];
    end

    // Capture the reduced result for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= chk_en_i & (|seg_bad);
    end

    assign err_o = err_q;

    // An error can only appear after a cycle in which checking was enabled.
    assert_err_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(chk_en_i));
endmodule

// File: rtl/ffm_slot_merge.sv
// ffm_slot_merge: combinational merge of one slot's registered fault sources
// into a code, the surviving refill request, the data-ok flag and the error
// flags. Assumes every input comes from the same capture edge.
module ffm_slot_merge
    import fetch_fault_pkg::*;
(
    input  logic       valid_i,
    input  logic       par_en_i,
    input  logic       xlat_i,
    input  logic       prot_i,
    input  logic       miss_i,
    input  logic       tag_bad_i,
    input  logic       data_bad_i,
    output exc_code_e  code_o,
    output logic       fill_req_o,
    output logic       data_ok_o,
    output logic       err_tag_o,
    output logic       err_data_o
);
    logic tag_af, data_af;

    // Integrity failures become faults only under the enable; data only on hits.
    always_comb begin
        tag_af  = par_en_i & tag_bad_i;
        data_af = par_en_i & data_bad_i & ~miss_i;
    end

    // Priority select of the exception code.
    always_comb begin
        if (!valid_i)              code_o = EXC_NONE;
        else if (xlat_i)           code_o = EXC_XLAT;
        else if (prot_i)           code_o = EXC_PROT;
        else if (tag_af | data_af) code_o = EXC_ACC;
        else                       code_o = EXC_NONE;
    end

    // Refill survives only a clean translation, protection and tag result.
    always_comb begin
        fill_req_o = valid_i & miss_i & ~xlat_i & ~prot_i & ~tag_af;
        data_ok_o  = valid_i & ~miss_i & (code_o == EXC_NONE);
        err_tag_o  = valid_i & tag_bad_i;
        err_data_o = valid_i & ~miss_i & data_bad_i;
    end
endmodule

// File: rtl/fetch_fault_merger.sv
// fetch_fault_merger: per-slot capture of translation/protection faults,
// miss intent and parity checks of the tag and data words, merged into one
// exception code per slot, refill cancellation and error reporting.
// Assumes all inputs for a slot arrive in the same cycle; outputs follow one
// rising edge later.
module fetch_fault_merger
    import fetch_fault_pkg::*;
#(
    parameter int SLOTS    = 2,
    parameter int TAG_W    = 20,
    parameter int TAG_SEG  = 10,
    parameter int DATA_W   = 32,
    parameter int DATA_SEG = 8,
    localparam int TAG_PB  = TAG_W / TAG_SEG,
    localparam int DATA_PB = DATA_W / DATA_SEG
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      parity_en_i,
    input  logic [SLOTS-1:0]          rd_valid_i,
    input  logic [SLOTS*TAG_W-1:0]    tag_word_i,
    input  logic [SLOTS*TAG_PB-1:0]   tag_par_i,
    input  logic [SLOTS*DATA_W-1:0]   data_word_i,
    input  logic [SLOTS*DATA_PB-1:0]  data_par_i,
    input  logic [SLOTS-1:0]          xlat_fault_i,
    input  logic [SLOTS-1:0]          prot_fault_i,
    input  logic [SLOTS-1:0]          miss_req_i,
    output logic [2*SLOTS-1:0]        exc_code_o,
    output logic [SLOTS-1:0]          fill_req_o,
    output logic [SLOTS-1:0]          data_ok_o,
    output logic [SLOTS-1:0]          err_tag_o,
    output logic [SLOTS-1:0]          err_data_o,
    output logic                      err_any_o
);
    logic par_en_q;

    // Capture the global enable alongside the slot data.
    always_ff @(posedge clk) begin
        if (!rst_n) par_en_q <= 1'b0;
        else        par_en_q <= parity_en_i;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic      valid_q, xlat_q, prot_q, miss_q;
        logic      tag_bad, data_bad;
        exc_code_e code;

        // Capture the slot's fault sources and miss intent.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                xlat_q  <= 1'b0;
                prot_q  <= 1'b0;
                miss_q  <= 1'b0;
            end else begin
                valid_q <= rd_valid_i[s];
                xlat_q  <= xlat_fault_i[s];
                prot_q  <= prot_fault_i[s];
                miss_q  <= miss_req_i[s];
            end
        end

        ffm_parity_check #(.W(TAG_W), .SEG(TAG_SEG)) u_tag_chk (
            .clk      (clk),
            .rst_n    (rst_n),
            .chk_en_i (rd_valid_i[s]),
            .word_i   (tag_word_i[s*TAG_W +: TAG_W]),
            .par_i    (tag_par_i[s*TAG_PB +: TAG_PB]),
            .err_o    (tag_bad)
        );

        ffm_parity_check #(.W(DATA_W), .SEG(DATA_SEG)) u_data_chk (
            .clk      (clk),
            .rst_n    (rst_n),
            .chk_en_i (rd_valid_i[s] & ~miss_req_i[s]),
            .word_i   (data_word_i[s*DATA_W +: DATA_W]),
            .par_i    (data_par_i[s*DATA_PB +: DATA_PB]),
            .err_o    (data_bad)
        );

        ffm_slot_merge u_merge (
            .valid_i    (valid_q),
            .par_en_i   (par_en_q),
            .xlat_i     (xlat_q),
            .prot_i     (prot_q),
            .miss_i     (miss_q),
            .tag_bad_i  (tag_bad),
            .data_bad_i (data_bad),
            .code_o     (code),
            .fill_req_o (fill_req_o[s]),
            .data_ok_o  (data_ok_o[s]),
            .err_tag_o  (err_tag_o[s]),
            .err_data_o (err_data_o[s])
        );

        assign exc_code_o[2*s +: 2] = code;

        // Translation fault always owns the code.
        assert_xlat_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_valid_i[s] & xlat_fault_i[s]) |-> code == EXC_XLAT);
        // With checking off no access fault is produced.
        assert_no_af_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(parity_en_i) |-> code != EXC_ACC);
        // A surviving request never carries a higher-priority fault.
        assert_req_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
            fill_req_o[s] |-> (code != EXC_XLAT && code != EXC_PROT && $past(miss_req_i[s])));
        // Delivered instructions are never flagged faulting or corrupt under enable.
        assert_data_ok_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
            data_ok_o[s] |-> (code == EXC_NONE && !(err_data_o[s] && par_en_q)));
        // Error reports only follow a valid slot.
        assert_err_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (err_tag_o[s] | err_data_o[s]) |-> $past(rd_valid_i[s]));
        // Data errors never reported for a missing slot.
        assert_miss_no_data_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(miss_req_i[s]) |-> !err_data_o[s]);
        // An idle slot stays quiet.
        assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rd_valid_i[s]) |-> (code == EXC_NONE && !fill_req_o[s] && !data_ok_o[s]));
    end

    // Aggregate error report across slots.
    always_comb err_any_o = (|err_tag_o) | (|err_data_o);
endmodule

// File: tb/fetch_fault_merger_tb.sv
module fetch_fault_merger_tb;
    localparam int SLOTS = 2, TAG_W = 20, TAG_SEG = 10, DATA_W = 32, DATA_SEG = 8;
    localparam int TAG_PB = TAG_W / TAG_SEG, DATA_PB = DATA_W / DATA_SEG;

    logic clk = 1'b0, rst_n = 1'b0, parity_en_i = 1'b0;
    logic [SLOTS-1:0] rd_valid_i = '0, xlat_fault_i = '0, prot_fault_i = '0, miss_req_i = '0;
    logic [SLOTS*TAG_W-1:0]   tag_word_i = '0;
    logic [SLOTS*TAG_PB-1:0]  tag_par_i = '0;
    logic [SLOTS*DATA_W-1:0]  data_word_i = '0;
    logic [SLOTS*DATA_PB-1:0] data_par_i = '0;
    logic [2*SLOTS-1:0] exc_code_o;
    logic [SLOTS-1:0] fill_req_o, data_ok_o, err_tag_o, err_data_o;
    logic err_any_o;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    fetch_fault_merger u_dut (.*);

    // Row: [12]valid [11]pen [10]xlat [9]prot [8]miss [7]tag flip [6]data flip
    //      [5:4]code [3]fill_req [2]data_ok [1]err_tag [0]err_data
    localparam logic [12:0] VEC [12] = '{
        13'b1_1_0_0_0_0_0_00_0_1_0_0, // clean hit (R8)
        13'b1_1_0_0_1_0_0_00_1_0_0_0, // clean miss (R7)
        13'b1_1_0_0_1_1_0_11_0_0_1_0, // tag flip cancels refill (R5)
        13'b1_0_0_0_1_1_0_00_1_0_1_0, // tag flip, checking off (R6, R9)
        13'b1_1_0_0_0_0_1_11_0_0_0_1, // data flip on hit (R5, R4)
        13'b1_0_0_0_0_0_1_00_0_1_0_1, // data flip, checking off (R6)
        13'b1_1_0_0_1_0_1_00_1_0_0_0, // data flip on miss ignored (R10)
        13'b1_1_1_1_1_1_0_01_0_0_1_0, // translation wins over all (R3)
        13'b1_1_0_1_0_0_1_10_0_0_0_1, // protection over access (R3)
        13'b1_1_1_0_0_0_0_01_0_0_0_0, // translation on hit (R3)
        13'b0_1_1_1_1_1_1_00_0_0_0_0, // invalid slot quiet (R11)
        13'b1_0_0_1_1_0_0_10_0_0_0_0  // protection cancels refill (R7)
    };

    function automatic logic [TAG_PB-1:0] tag_par(input logic [TAG_W-1:0] w);
        logic [TAG_PB-1:0] p;
        for (int g = 0; g < TAG_PB; g++) p[g] = ^w[g*TAG_SEG +: TAG_SEG];
        return p;
    endfunction

    function automatic logic [DATA_PB-1:0] data_par(input logic [DATA_W-1:0] w);
        logic [DATA_PB-1:0] p;
        for (int g = 0; g < DATA_PB; g++) p[g] = ^w[g*DATA_SEG +: DATA_SEG];
        return p;
    endfunction

    // Expected {code, req, dok, etag, edata} from the requirement text.
    function automatic logic [5:0] model(input logic v, pen, x, p, m, ft, fd);
        logic [1:0] c; logic tagf, dataf;
        dataf = fd & ~m;
        tagf  = ft;
        if (!v) return 6'b0;
        if (x) c = 2'b01; else if (p) c = 2'b10;
        else if (pen & (tagf | dataf)) c = 2'b11; else c = 2'b00;
        return {c, m & ~x & ~p & ~(pen & tagf), ~m & (c == 2'b00), tagf, dataf};
    endfunction

    // Drive one slot; flips corrupt a word bit or a parity bit at position pos.
    task automatic drive_slot(input int s, input logic v, x, p, m, ft, fd, input int seed);
        logic [TAG_W-1:0] tw; logic [DATA_W-1:0] dw;
        logic [TAG_PB-1:0] tp; logic [DATA_PB-1:0] dp;
        tw = TAG_W'(seed * 7919 + 13);
        dw = DATA_W'(seed * 104729 + 977);
        tp = tag_par(tw); dp = data_par(dw);
        if (ft) begin
            if (seed % 5 == 0) tp[seed % TAG_PB] = ~tp[seed % TAG_PB];
            else tw[seed % TAG_W] = ~tw[seed % TAG_W];
        end
        if (fd) begin
            if (seed % 7 == 0) dp[seed % DATA_PB] = ~dp[seed % DATA_PB];
            else dw[(seed * 3) % DATA_W] = ~dw[(seed * 3) % DATA_W];
        end
        rd_valid_i[s] = v; xlat_fault_i[s] = x; prot_fault_i[s] = p; miss_req_i[s] = m;
        tag_word_i[s*TAG_W +: TAG_W] = tw;   tag_par_i[s*TAG_PB +: TAG_PB] = tp;
        data_word_i[s*DATA_W +: DATA_W] = dw; data_par_i[s*DATA_PB +: DATA_PB] = dp;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input int tagn);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s case %0d: actual %b expected %b", req, tagn, act, exp);
        end
    endtask

    task automatic check_slot(input int s, input logic [5:0] e, input int tagn);
        check("R3 code", 8'(exc_code_o[2*s +: 2]), 8'(e[5:4]), tagn);
        check("R7 fill_req", 8'(fill_req_o[s]), 8'(e[3]), tagn);
        check("R8 data_ok", 8'(data_ok_o[s]), 8'(e[2]), tagn);
        check("R9 err_tag", 8'(err_tag_o[s]), 8'(e[1]), tagn);
        check("R9 err_data", 8'(err_data_o[s]), 8'(e[0]), tagn);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] e0, e1;
        // R1: reset with active stimulus
        drive_slot(0, 1, 0, 0, 1, 1, 0, 3);
        drive_slot(1, 1, 0, 0, 0, 0, 1, 4);
        parity_en_i = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {exc_code_o, fill_req_o, data_ok_o}, 8'h00, 0);
        check("R1 reset errors", {5'b0, err_tag_o[0], err_data_o[1], err_any_o}, 8'h00, 0);
        @(negedge clk); rst_n = 1;

        // Table walk: slot 0 from the table, slot 1 a clean hit.
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            parity_en_i = VEC[i][11];
            drive_slot(0, VEC[i][12], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], i + 1);
            drive_slot(1, 1, 0, 0, 0, 0, 0, i + 40);
            @(posedge clk); #1;
            check_slot(0, VEC[i][5:0], 100 + i);
            check_slot(1, 6'b00_0_1_0_0, 200 + i);
            check("R9 err_any", 8'(err_any_o), 8'(VEC[i][1] | VEC[i][0]), 300 + i);
        end

        // Exhaustive walk (R4, R5, R6, R10) on both slots with different patterns.
        for (int k = 0; k < 64; k++) begin
            logic [5:0] b0, b1;
            b0 = 6'(k); b1 = 6'(k) ^ 6'b011010;
            @(negedge clk);
            parity_en_i = b0[5];
            drive_slot(0, 1, b0[4], b0[3], b0[2], b0[1], b0[0], k + 11);
            drive_slot(1, 1, b1[4], b1[3], b1[2], b1[1], b1[0], k + 71);
            e0 = model(1, b0[5], b0[4], b0[3], b0[2], b0[1], b0[0]);
            e1 = model(1, b0[5], b1[4], b1[3], b1[2], b1[1], b1[0]);
            @(posedge clk); #1;
            check_slot(0, e0, 400 + k);
            check_slot(1, e1, 500 + k);
        end

        // R2: outputs hold while inputs change between edges.
        @(negedge clk);
        parity_en_i = 1;
        drive_slot(0, 1, 0, 0, 0, 1, 0, 9);
        drive_slot(1, 1, 0, 0, 1, 0, 0, 10);
        @(posedge clk); #1;
        e0 = model(1, 1, 0, 0, 0, 1, 0);
        e1 = model(1, 1, 0, 0, 1, 0, 0);
        check_slot(0, e0, 600); check_slot(1, e1, 601);
        @(negedge clk);
        drive_slot(0, 1, 1, 0, 1, 0, 0, 12);
        drive_slot(1, 0, 0, 0, 0, 0, 0, 13);
        #1;
        check("R2 hold code", 8'(exc_code_o), 8'({e1[5:4], e0[5:4]}), 602);
        check("R2 hold req", 8'(fill_req_o), 8'({e1[3], e0[3]}), 603);
        @(posedge clk); #1;
        check_slot(0, model(1, 1, 1, 0, 1, 0, 0), 604);
        check_slot(1, 6'b0, 605);  // R11 idle slot

        // R1: reset in the middle of activity clears outputs after one edge.
        @(negedge clk);
        drive_slot(0, 1, 0, 0, 0, 0, 1, 14);
        rst_n = 0;
        @(posedge clk); #1;
        check("R1 mid reset", {exc_code_o, fill_req_o, data_ok_o}, 8'h00, 700);
        check("R1 mid reset err", 8'(err_any_o), 8'h00, 701);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check_slot(0, model(1, 1, 0, 0, 0, 0, 1), 702);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule